// File: doc/BRIEF.md
# Graphic LCD Host RAM Port

This block is the host-facing side of a graphic LCD controller. An 8-bit microprocessor bus with active-low chip enable, read and write strobes, and a data/instruction flag reaches an internal display memory. The memory is organised as 64 rows by up to 22 columns. A row pointer and a column pointer form the address. After every display-data transfer, one of the two pointers moves by one position. Single-byte commands choose which pointer moves and in which direction. Other commands set either pointer directly or pick the word width.

Reads are pipelined through a holding register. A read returns what the holding register already contained. The word at the current address is then fetched into the holding register and the pointer moves. The first read after an address is set is therefore a dummy read. The host must issue a second read to obtain the addressed word.

The strobes are sampled on the system clock. Each falling edge of a strobe, taken while chip enable is low, counts as one transfer.

Top module: `lcd_ram_port`

## Requirements
- R1: After reset the row and column pointers are 0, the word width is 8 bits, the row pointer is the one that moves, the direction is upward, and both `dout` and the holding register are 0.
- R2: A data write (`di`=1) stores `din` at {row, column}. In 6-bit width, bits 7:6 are stored as zero.
- R3: A data read sets `dout` to the previous holding-register value and then loads the holding register from the current address. The first read after setting an address therefore returns stale content.
- R4: Each data read or write moves only the selected pointer, by +1 when the direction is upward and by -1 when it is downward.
- R5: The row pointer wraps from 63 to 0 going up and from 0 to 63 going down.
- R6: The column pointer wraps between 0 and its last position. The last position is 15 in 8-bit width and 21 in 6-bit width.
- R7: Command 0x04 to 0x07 chooses the moving pointer and the direction. Bit 1 selects the pointer (0 = row, 1 = column). Bit 0 selects the direction (1 = up).
- R8: Command 0x80|r sets the row to r. Command 0x20|c sets the column to c only if c is at most the last position; otherwise it has no effect. Commands that match no encoding have no effect.
- R9: Command 0x00 selects 6-bit width and 0x01 selects 8-bit width. Entering 8-bit width while the column is above 15 resets the column to 0.
- R10: Only a strobe's falling edge with `cs_n` low counts as a transfer, so a held strobe counts once. An instruction read (`di`=0) changes neither `dout` nor the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip enable |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| di | input | 1 | 1 = display data, 0 = instruction |
| din | input | 8 | Bus byte from the host |
| dout | output | 8 | Read data returned to the host |

## Verification
The assertions check on every cycle that the column pointer stays within the range of the current width. They also check that cycles without a transfer leave the pointers and `dout` unchanged, that a row-stepping access changes the row but not the column, and that `dout` after a data read equals the holding register from before the read. Other behaviours can only be shown by the bench's scenarios: masking to 6 bits, wrap-around at both ends, the dummy-read sequence after an address change, rejection of out-of-range column commands, and the column reset on a width switch. The bench checks these through read-back against a reference model.

// File: rtl/lcd_ram_port.sv
module lcd_ram_port #(
  parameter int ROWS    = 64,
  parameter int COLS_W8 = 16,
  parameter int COLS_W6 = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       di,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS_W6);
  localparam int DEPTH = ROWS << CW;

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          mode8, dir_up, sel_col;
  logic          rd_q, wr_q, load_q;
  logic [7:0]    oreg, ram_q;
  logic [7:0]    mem [DEPTH];

  wire rd_fall = !cs_n && rd_q && !rd_n;
  wire wr_fall = !cs_n && wr_q && !wr_n;
  wire dat_rd  = rd_fall && di;
  wire dat_wr  = wr_fall && di && !rd_fall;
  wire cmd_wr  = wr_fall && !di && !rd_fall;
  wire step    = dat_rd || dat_wr;

  wire [CW-1:0]    last_col = mode8 ? CW'(COLS_W8 - 1) : CW'(COLS_W6 - 1);
  wire [RW+CW-1:0] addr     = {row, col};
  wire [CW-1:0]    col_nxt  = dir_up ? ((col == last_col) ? '0 : col + 1'b1)
                                     : ((col == '0) ? last_col : col - 1'b1);
  wire [RW-1:0]    row_nxt  = dir_up ? ((row == RW'(ROWS - 1)) ? '0 : row + 1'b1)
                                     : ((row == '0) ? RW'(ROWS - 1) : row - 1'b1);

  always_ff @(posedge clk) begin
    if (dat_wr) mem[addr] <= mode8 ? din : {2'b00, din[5:0]};
    if (dat_rd) ram_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b1;
      wr_q    <= 1'b1;
      load_q  <= 1'b0;
      row     <= '0;
      col     <= '0;
      mode8   <= 1'b1;
      dir_up  <= 1'b1;
      sel_col <= 1'b0;
      oreg    <= '0;
      dout    <= '0;
    end else begin
      rd_q   <= rd_n;
      wr_q   <= wr_n;
      load_q <= dat_rd;
      if (load_q) oreg <= ram_q;
      if (dat_rd) dout <= oreg;
      if (cmd_wr) begin
        if (din[7:6] == 2'b10) row <= RW'(din[5:0]);
        else if (din[7:5] == 3'b001) begin
          if (CW'(din[4:0]) <= last_col) col <= CW'(din[4:0]);
        end else if (din[7:2] == 6'b000001) begin
          sel_col <= din[1];
          dir_up  <= din[0];
        end else if (din[7:1] == 7'd0) begin
          mode8 <= din[0];
          if (din[0] && col > CW'(COLS_W8 - 1)) col <= '0;
        end
      end else if (step) begin
        if (sel_col) col <= col_nxt;
        else         row <= row_nxt;
      end
    end
  end

  a_r6_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    col <= last_col);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fall || wr_fall) |=> $stable(row) && $stable(col) && $stable(dout));

  a_r4_row_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sel_col) |=> (row != $past(row)) && $stable(col));

  a_r3_stale_return: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> dout == $past(oreg));
endmodule

// File: tb/sim_lcd_ram_port.sv
module sim_lcd_ram_port;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1, di = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  int n_chk = 0, n_fail = 0;

  logic [7:0] m_mem [64][22];
  int m_row, m_col;
  bit m_mode8, m_up, m_sel;
  logic [7:0] m_oreg;

  always #(CLK_P/2) clk = ~clk;

  lcd_ram_port u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
                   .wr_n(wr_n), .di(di), .din(din), .dout(dout));

  function automatic int last_c();
    return m_mode8 ? 15 : 21;
  endfunction

  task automatic m_step();
    if (m_sel) m_col = m_up ? ((m_col == last_c()) ? 0 : m_col + 1) : ((m_col == 0) ? last_c() : m_col - 1);
    else       m_row = m_up ? ((m_row == 63) ? 0 : m_row + 1) : ((m_row == 0) ? 63 : m_row - 1);
  endtask

  task automatic m_cmd(input logic [7:0] v);
    if (v[7:6] == 2'b10) m_row = int'(v[5:0]);
    else if (v[7:5] == 3'b001) begin
      if (int'(v[4:0]) <= last_c()) m_col = int'(v[4:0]);
    end else if (v[7:2] == 6'b000001) begin
      m_sel = v[1]; m_up = v[0];
    end else if (v[7:1] == 7'd0) begin
      m_mode8 = v[0];
      if (m_mode8 && m_col > 15) m_col = 0;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic strobe_wr(input bit d, input logic [7:0] v, input bit sel);
    @(negedge clk); cs_n = !sel; di = d; din = v; wr_n = 0;
    repeat (2) @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic strobe_rd(input bit d, input int hold, output logic [7:0] v);
    @(negedge clk); cs_n = 0; di = d; rd_n = 0;
    repeat (hold) @(negedge clk); v = dout; rd_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic cmd(input logic [7:0] v);
    strobe_wr(1'b0, v, 1'b1); m_cmd(v);
  endtask

  task automatic wdat(input logic [7:0] v);
    strobe_wr(1'b1, v, 1'b1);
    m_mem[m_row][m_col] = m_mode8 ? v : {2'b00, v[5:0]};
    m_step();
  endtask

  task automatic rdat(input string tag, input bit check, input int hold);
    logic [7:0] got, exp;
    strobe_rd(1'b1, hold, got);
    exp = m_oreg; m_oreg = m_mem[m_row][m_col]; m_step();
    if (check) chk(tag, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, last;
    void'($urandom(32'd4711));
    m_row = 0; m_col = 0; m_mode8 = 1; m_up = 1; m_sel = 0; m_oreg = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 dout reset", dout, 8'h00);
    // R1 defaults: 8-bit width, row moves upward from 0
    wdat(8'hA5); wdat(8'h3C);
    cmd(8'h80);
    rdat("R1 held reg zero", 1, 2);
    rdat("R3 first addressed word", 1, 2);
    rdat("R4 row stepped up", 1, 2);
    // fill memory in 6-bit width, column moving
    cmd(8'h00); cmd(8'h07);
    for (int r = 0; r < 64; r++) begin
      cmd(8'h80 | 8'(r)); cmd(8'h20);
      for (int c = 0; c < 22; c++) wdat(8'($urandom));
    end
    cmd(8'h80); cmd(8'h20);
    rdat("prime", 0, 2);
    // R5 row wrap both ways
    cmd(8'h01); cmd(8'h05); cmd(8'hBF);
    wdat(8'h11); wdat(8'h22);
    cmd(8'h04); cmd(8'h80);
    rdat("R3 dummy after set row", 1, 2);
    rdat("R5 row0 after wrap up", 1, 2);
    rdat("R5 row63 after wrap down", 1, 2);
    // R6 column wrap in 6-bit, R2 masking
    cmd(8'h00); cmd(8'h07); cmd(8'h35);
    wdat(8'hCF); wdat(8'h12);
    cmd(8'h06); cmd(8'h20);
    rdat("R3 dummy after set col", 1, 2);
    rdat("R6 col0 after wrap up", 1, 2);
    rdat("R2 masked byte at col21", 1, 2);
    // R9 width switch with col 20 -> 0; R6 8-bit wrap; R8 ignored column
    cmd(8'h01); cmd(8'h2F); cmd(8'h07);
    wdat(8'h99); wdat(8'h77);
    cmd(8'h30); wdat(8'h55);
    cmd(8'h2F);
    rdat("R3 dummy", 1, 2);
    rdat("R6 col15", 1, 2);
    rdat("R6 col0 8-bit wrap", 1, 2);
    rdat("R8 out of range col ignored", 1, 2);
    cmd(8'h00); cmd(8'h35); cmd(8'h01);
    rdat("R9 col reset on width switch", 1, 2);
    rdat("R9 next", 1, 2);
    // R10 held strobe, deselected strobe, instruction read
    rdat("R10 held strobe counts once", 1, 7);
    rdat("R10 after held", 1, 2);
    strobe_wr(1'b1, 8'hEE, 1'b0);
    rdat("R10 deselected write ignored", 1, 2);
    last = dout;
    strobe_rd(1'b0, 2, v);
    chk("R10 instruction read dout", v, last);
    rdat("R10 pointers after instruction read", 1, 2);
    // R7 direction/select, R8 ignored codes
    cmd(8'h06); cmd(8'h7F); cmd(8'hC3); cmd(8'h02);
    rdat("R7 R8 column down", 1, 2);
    rdat("R7 column down again", 1, 2);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom % 100);
      if (k < 30) wdat(8'($urandom));
      else if (k < 60) rdat("R3 R4 random read", 1, 2 + int'($urandom % 3));
      else if (k < 68) cmd(8'h80 | 8'($urandom % 64));
      else if (k < 76) cmd(8'h20 | 8'($urandom % 32));
      else if (k < 84) cmd(8'h04 | 8'($urandom % 4));
      else if (k < 88) cmd(8'($urandom % 2));
      else if (k < 92) begin
        v = 8'($urandom);
        if (v[7:6] == 2'b10 || v[7:5] == 3'b001 || v[7:2] == 6'b000001 || v[7:1] == 7'd0) v = 8'h40;
        cmd(v);
      end else if (k < 96) begin
        last = dout;
        strobe_rd(1'b0, 2, v);
        chk("R10 random instruction read", v, last);
      end else strobe_wr(1'b1, 8'($urandom), 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule